// File: doc/BRIEF.md
# I2C Configuration Target with Strap-Selected Address

This block is the serial configuration port of a multiphase regulator controller. It sits on a two-wire I2C bus as a target device. A 3-bit strap code is captured once when reset is released. That code picks the device address and the power-up load-line percentage together. After power-up a bus master can retune the load line, overwrite the two fixed phase-count zone selections and the phase-shedding thresholds, and read back the live phase status supplied by the PWM channel logic.

Each register value is driven straight to the neighbouring blocks. A threshold byte of 0xFF means that the threshold is disabled, and a per-threshold enable flag reports this. The block runs on the system clock and oversamples SCL and SDA through synchronizer flops. Its SDA pad is modelled as three signals: an input, an output value, and an output enable that pulls the line low.

Register map (pointer values): 0x00 load-line percentage, 0x01 run-time low-phase zone, 0x02 boot low-phase zone, 0x03 to 0x06 shedding thresholds 1 to 4, 0x07 phase status (read-only). Every other pointer value is unmapped.

Top module: `cfg_i2c_target`

## Requirements
- R1: The captured strap code k selects the 7-bit address 0x20 + 0x10*(k>>1), which is driven on `dev_addr` (codes 0/1 give 0x20, 2/3 give 0x30, 4/5 give 0x40, 6/7 give 0x50).
- R2: The load-line register powers up to 100 (0x64) for an even strap code and to 0 for an odd strap code.
- R3: The strap code is sampled only on the first clock after reset is released. Later changes on `strap_code` change neither the address nor any register.
- R4: The sequence START, address with R/W bit 0, pointer byte, data byte writes the data into the register at the pointer. The target acknowledges each of the three bytes by holding SDA low during the ninth SCL pulse.
- R5: The pointer advances by one after every data byte written or read. Consecutive data bytes in one write therefore fill consecutive registers.
- R6: A read (address with R/W bit 1) returns the register at the current pointer MSB first. The target keeps sending further bytes while the master acknowledges. After a master NACK it releases SDA, and the pointer keeps its advanced value for the next transfer.
- R7: When the address byte does not match, the target does not acknowledge. It then ignores every following byte until the next START, and leaves all registers unchanged.
- R8: The shedding-threshold enable bit i is 0 exactly when threshold register i holds 0xFF, and 1 for any other value.
- R9: Pointer 0x07 reads the current value of `phase_status`. A write to it is acknowledged and changes no output.
- R10: A write to an unmapped pointer is acknowledged and changes no output. A read from an unmapped pointer returns 0x00.
- R11: After reset the run-time zone register is 0x00, the boot zone register is 0x03, every threshold register is 0xFF (all enables 0), and SDA is not driven.
- R12: The target changes its SDA drive only while SCL is low, and it does not drive SDA once a STOP has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_code | input | 3 | Strap setting, captured after reset release |
| phase_status | input | 8 | Live active-phase pattern from the PWM logic |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| sda_o | output | 1 | SDA output value (always 0, open-drain) |
| sda_oe | output | 1 | SDA output enable; 1 pulls SDA low |
| dev_addr | output | 7 | Device address selected by the strap |
| loadline_pct | output | 8 | Load-line percentage register |
| lpc_run | output | 8 | Run-time low-phase zone register |
| lpc_boot | output | 8 | Boot low-phase zone register |
| shed_thr | output | NUM_THR*8 | Shedding thresholds, threshold i in bits [8i+7:8i] |
| shed_en | output | NUM_THR | Threshold enable flags (0 when the register is 0xFF) |

## Verification
The bound checker watches three things on every cycle. The strap-derived address must stay on the 0x20 to 0x50 grid and never move after capture. A configuration output may change only in the cycle after an internal write strobe. SDA drive may switch on only while SCL is low. The decoding of all eight strap codes, the acknowledge pattern, the pointer auto-increment across bytes and across transfers, and the silence after a foreign address can only be shown by complete bus transfers. The same holds for the read-only and unmapped registers and the 0xFF disable sentinel. The bench drives these as directed bit-level I2C sequences.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } bus_state_t;

   localparam logic [6:0] ADDR_BASE = 7'h20;
   localparam logic [7:0] LL_FULL   = 8'd100;

   // Strap code k: address steps by 0x10 for every pair of codes
   function automatic logic [6:0] strap_to_addr(input logic [2:0] code);
      return ADDR_BASE + {1'b0, code[2:1], 4'b0000};
   endfunction

   // Even codes select the full load line, odd codes select none
   function automatic logic [7:0] strap_to_ll(input logic [2:0] code);
      return code[0] ? 8'd0 : LL_FULL;
   endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   localparam int unsigned MSB = STAGES - 1;

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_d    <= scl_pipe[MSB];
         sda_d    <= sda_pipe[MSB];
      end
   end

   assign scl_s     = scl_pipe[MSB];
   assign sda_s     = sda_pipe[MSB];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
   import cfg_i2c_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [6:0] my_addr,
   input  logic       addr_ok,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic [7:0] ptr,
   output logic       wr_en,
   output logic [7:0] wr_data
);

   localparam logic [3:0] BYTE_BITS = 4'd8;
   localparam logic [3:0] LAST_BIT  = 4'd7;

   bus_state_t state;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic       rw;
   logic       mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise && bitcnt != BYTE_BITS) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == BYTE_BITS) begin
                     bitcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (addr_ok && shreg[7:1] == my_addr) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr    <= shreg;
                        sda_oe <= 1'b1;
                        state  <= ST_PTR_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_data <= shreg;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 8'd1;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 8'd1;
                        state  <= ST_RACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        bitcnt <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        state  <= ST_RDATA;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
   import cfg_i2c_pkg::*;
#(
   parameter int unsigned NUM_THR      = 4,
   parameter logic [7:0]  LPC_RUN_RST  = 8'h00,
   parameter logic [7:0]  LPC_BOOT_RST = 8'h03,
   parameter logic [7:0]  THR_RST      = 8'hFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           strap_code,
   input  logic [7:0]           phase_status,
   input  logic                 wr_en,
   input  logic [7:0]           idx,
   input  logic [7:0]           wr_data,
   output logic [7:0]           rd_data,
   output logic [6:0]           dev_addr,
   output logic                 addr_ok,
   output logic [7:0]           loadline_pct,
   output logic [7:0]           lpc_run,
   output logic [7:0]           lpc_boot,
   output logic [NUM_THR*8-1:0] shed_thr,
   output logic [NUM_THR-1:0]   shed_en
);

   localparam logic [7:0] IDX_LL   = 8'h00;
   localparam logic [7:0] IDX_RUN  = 8'h01;
   localparam logic [7:0] IDX_BOOT = 8'h02;
   localparam logic [7:0] IDX_THR0 = 8'h03;
   localparam logic [7:0] IDX_STAT = IDX_THR0 + 8'(NUM_THR);
   localparam logic [7:0] THR_OFF  = 8'hFF;

   logic [2:0] strap_q;
   logic       loaded;
   logic [7:0] thr_q [NUM_THR];

   // Strap capture happens once, on the first clock after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded       <= 1'b0;
         strap_q      <= '0;
         loadline_pct <= '0;
      end else if (!loaded) begin
         loaded       <= 1'b1;
         strap_q      <= strap_code;
         loadline_pct <= strap_to_ll(strap_code);
      end else if (wr_en && idx == IDX_LL) begin
         loadline_pct <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpc_run  <= LPC_RUN_RST;
         lpc_boot <= LPC_BOOT_RST;
      end else if (wr_en) begin
         if (idx == IDX_RUN)  lpc_run  <= wr_data;
         if (idx == IDX_BOOT) lpc_boot <= wr_data;
      end
   end

   for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q[i] <= THR_RST;
         end else if (wr_en && idx == IDX_THR0 + 8'(i)) begin
            thr_q[i] <= wr_data;
         end
      end
      assign shed_thr[i*8 +: 8] = thr_q[i];
      assign shed_en[i]         = (thr_q[i] != THR_OFF);
   end

   always_comb begin
      rd_data = 8'h00;
      if (idx == IDX_LL)   rd_data = loadline_pct;
      if (idx == IDX_RUN)  rd_data = lpc_run;
      if (idx == IDX_BOOT) rd_data = lpc_boot;
      if (idx == IDX_STAT) rd_data = phase_status;
      for (int i = 0; i < NUM_THR; i++) begin
         if (idx == IDX_THR0 + 8'(i)) rd_data = thr_q[i];
      end
   end

   assign dev_addr = strap_to_addr(strap_q);
   assign addr_ok  = loaded;

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
   import cfg_i2c_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned NUM_THR      = 4,
   parameter logic [7:0]  LPC_RUN_RST  = 8'h00,
   parameter logic [7:0]  LPC_BOOT_RST = 8'h03,
   parameter logic [7:0]  THR_RST      = 8'hFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           strap_code,
   input  logic [7:0]           phase_status,
   input  logic                 scl_in,
   input  logic                 sda_in,
   output logic                 sda_o,
   output logic                 sda_oe,
   output logic [6:0]           dev_addr,
   output logic [7:0]           loadline_pct,
   output logic [7:0]           lpc_run,
   output logic [7:0]           lpc_boot,
   output logic [NUM_THR*8-1:0] shed_thr,
   output logic [NUM_THR-1:0]   shed_en
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_i2c_target: SYNC_STAGES must be at least 2");
   end
   if (NUM_THR < 1 || NUM_THR > 8) begin : g_bad_thr
      $error("cfg_i2c_target: NUM_THR must lie in 1..8");
   end

   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic       addr_ok;
   logic [7:0] ptr;
   logic       cfg_wr;
   logic [7:0] cfg_wdata;
   logic [7:0] cfg_rdata;

   cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_in),
      .sda_raw   (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   cfg_i2c_engine u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .my_addr   (dev_addr),
      .addr_ok   (addr_ok),
      .rd_data   (cfg_rdata),
      .sda_oe    (sda_oe),
      .ptr       (ptr),
      .wr_en     (cfg_wr),
      .wr_data   (cfg_wdata)
   );

   cfg_i2c_regs #(
      .NUM_THR      (NUM_THR),
      .LPC_RUN_RST  (LPC_RUN_RST),
      .LPC_BOOT_RST (LPC_BOOT_RST),
      .THR_RST      (THR_RST)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_code   (strap_code),
      .phase_status (phase_status),
      .wr_en        (cfg_wr),
      .idx          (ptr),
      .wr_data      (cfg_wdata),
      .rd_data      (cfg_rdata),
      .dev_addr     (dev_addr),
      .addr_ok      (addr_ok),
      .loadline_pct (loadline_pct),
      .lpc_run      (lpc_run),
      .lpc_boot     (lpc_boot),
      .shed_thr     (shed_thr),
      .shed_en      (shed_en)
   );

   assign sda_o = 1'b0;

endmodule

// File: rtl/cfg_i2c_chk.sv
module cfg_i2c_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_in,
   input logic       sda_oe,
   input logic [6:0] dev_addr,
   input logic [7:0] loadline_pct,
   input logic [7:0] lpc_run,
   input logic       cfg_wr
);

   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_ADDR_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (dev_addr[3:0] == 4'h0 && dev_addr >= 7'h20 && dev_addr <= 7'h50)); // R1

   AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> $stable(dev_addr)); // R3

   AST_LL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !$stable(loadline_pct)) |-> $past(cfg_wr)); // R4

   AST_RUN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !$stable(lpc_run)) |-> $past(cfg_wr)); // R4

   AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_in); // R12

endmodule

bind cfg_i2c_target cfg_i2c_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_in       (scl_in),
   .sda_oe       (sda_oe),
   .dev_addr     (dev_addr),
   .loadline_pct (loadline_pct),
   .lpc_run      (lpc_run),
   .cfg_wr       (cfg_wr)
);

// File: tb/cfg_i2c_target_test.sv
`timescale 1ns/1ps
module cfg_i2c_target_test;

   localparam int T = 20;
   localparam logic [6:0] MY_ADDR = 7'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  strap_code = 3'd2;
   logic [7:0]  phase_status = 8'h00;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_o;
   logic        sda_oe;
   logic [6:0]  dev_addr;
   logic [7:0]  loadline_pct;
   logic [7:0]  lpc_run;
   logic [7:0]  lpc_boot;
   logic [31:0] shed_thr;
   logic [3:0]  shed_en;
   logic        sda_bus;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   assign sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

   cfg_i2c_target uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_code   (strap_code),
      .phase_status (phase_status),
      .scl_in       (m_scl),
      .sda_in       (sda_bus),
      .sda_o        (sda_o),
      .sda_oe       (sda_oe),
      .dev_addr     (dev_addr),
      .loadline_pct (loadline_pct),
      .lpc_run      (lpc_run),
      .lpc_boot     (lpc_boot),
      .shed_thr     (shed_thr),
      .shed_en      (shed_en)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b0; tick(T);
      m_scl = 1'b0; tick(T);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b1; tick(T);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(T);
         m_scl = 1'b1; tick(2*T);
         m_scl = 1'b0; tick(T);
      end
      m_sda = 1'b1; tick(T);
      m_scl = 1'b1; tick(T);
      ack = ~sda_bus;
      tick(T);
      m_scl = 1'b0; tick(T);
   endtask

   task automatic rbyte(input logic nack, output logic [7:0] b);
      m_sda = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         tick(T);
         m_scl = 1'b1; tick(T);
         b = {b[6:0], sda_bus};
         tick(T);
         m_scl = 1'b0;
      end
      tick(T);
      m_sda = nack; tick(T);
      m_scl = 1'b1; tick(2*T);
      m_scl = 1'b0; tick(T);
      m_sda = 1'b1;
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d, input string req);
      logic a0, a1, a2;
      bus_start();
      wbyte({MY_ADDR, 1'b0}, a0);
      wbyte(idx, a1);
      wbyte(d, a2);
      bus_stop();
      chk(req, {29'd0, a0, a1, a2}, 32'h7);
   endtask

   task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
      logic a;
      bus_start();
      wbyte({MY_ADDR, 1'b0}, a);
      wbyte(idx, a);
      bus_start();
      wbyte({MY_ADDR, 1'b1}, a);
      rbyte(1'b1, d);
      bus_stop();
   endtask

   // R1 R2 R11: every strap code, then reset defaults
   task automatic t_strap();
      for (int k = 0; k < 8; k++) begin
         strap_code = 3'(k);
         rst_n = 1'b0; tick(5);
         rst_n = 1'b1; tick(5);
         chk("R1 strap address", {25'd0, dev_addr}, 32'h20 + 32'((k / 2) * 16));
         chk("R2 strap load line", {24'd0, loadline_pct}, (k % 2 == 0) ? 32'd100 : 32'd0);
      end
      strap_code = 3'd2;
      rst_n = 1'b0; tick(5);
      rst_n = 1'b1; tick(5);
      chk("R11 run zone reset", {24'd0, lpc_run}, 32'h00);
      chk("R11 boot zone reset", {24'd0, lpc_boot}, 32'h03);
      chk("R11 thresholds reset", shed_thr, 32'hFFFF_FFFF);
      chk("R11 enables reset", {28'd0, shed_en}, 32'h0);
      chk("R11 sda idle", {31'd0, sda_oe}, 32'h0);
   endtask

   // R3: strap moves after capture
   task automatic t_strap_hold();
      logic [7:0] d;
      strap_code = 3'd7;
      tick(10);
      chk("R3 address held", {25'd0, dev_addr}, 32'h30);
      chk("R3 load line held", {24'd0, loadline_pct}, 32'h64);
      reg_rd(8'h00, d);
      chk("R3 read via captured address", {24'd0, d}, 32'h64);
      strap_code = 3'd2;
   endtask

   // R4: single-byte writes
   task automatic t_write();
      reg_wr(8'h00, 8'h55, "R4 ack load line write");
      chk("R4 load line", {24'd0, loadline_pct}, 32'h55);
      reg_wr(8'h01, 8'h04, "R4 ack run zone write");
      chk("R4 run zone", {24'd0, lpc_run}, 32'h04);
      reg_wr(8'h02, 8'h01, "R4 ack boot zone write");
      chk("R4 boot zone", {24'd0, lpc_boot}, 32'h01);
   endtask

   // R6 R12: burst read, NACK, pointer carried over
   task automatic t_read();
      logic a;
      logic [7:0] d;
      bus_start();
      wbyte({MY_ADDR, 1'b0}, a);
      wbyte(8'h00, a);
      bus_start();
      wbyte({MY_ADDR, 1'b1}, a);
      chk("R6 read address ack", {31'd0, a}, 32'h1);
      rbyte(1'b0, d);
      chk("R6 first byte", {24'd0, d}, 32'h55);
      rbyte(1'b0, d);
      chk("R6 second byte", {24'd0, d}, 32'h04);
      rbyte(1'b1, d);
      chk("R6 third byte", {24'd0, d}, 32'h01);
      bus_stop();
      chk("R12 released after stop", {31'd0, sda_oe}, 32'h0);
      bus_start();
      wbyte({MY_ADDR, 1'b1}, a);
      rbyte(1'b1, d);
      bus_stop();
      chk("R6 pointer carried over", {24'd0, d}, 32'hFF);
   endtask

   // R5 R8: burst write into thresholds, sentinel handling
   task automatic t_thresholds();
      logic a0, a1, a2, a3;
      bus_start();
      wbyte({MY_ADDR, 1'b0}, a0);
      wbyte(8'h03, a1);
      wbyte(8'h10, a2);
      wbyte(8'h20, a3);
      bus_stop();
      chk("R5 burst write acks", {28'd0, a0, a1, a2, a3}, 32'hF);
      chk("R5 burst write values", shed_thr, 32'hFFFF_2010);
      chk("R8 enables after burst", {28'd0, shed_en}, 32'h3);
      reg_wr(8'h04, 8'hFF, "R8 ack sentinel write");
      chk("R8 sentinel disables", {28'd0, shed_en}, 32'h1);
      reg_wr(8'h06, 8'hFE, "R8 ack near-sentinel write");
      chk("R8 0xFE enables", {28'd0, shed_en}, 32'h9);
   endtask

   // R9: read-only status
   task automatic t_status();
      logic [7:0] d;
      phase_status = 8'hA5;
      reg_wr(8'h07, 8'h3C, "R9 ack status write");
      chk("R9 write leaves load line", {24'd0, loadline_pct}, 32'h55);
      chk("R9 write leaves thresholds", shed_thr, 32'hFEFF_FF10);
      reg_rd(8'h07, d);
      chk("R9 status read", {24'd0, d}, 32'hA5);
      phase_status = 8'h0F;
      reg_rd(8'h07, d);
      chk("R9 status follows input", {24'd0, d}, 32'h0F);
   endtask

   // R10: unmapped pointer
   task automatic t_unmapped();
      logic [7:0] d;
      reg_wr(8'h2A, 8'h77, "R10 ack unmapped write");
      chk("R10 outputs unchanged", {lpc_boot, lpc_run, loadline_pct}, 32'h0001_0455);
      chk("R10 thresholds unchanged", shed_thr, 32'hFEFF_FF10);
      reg_rd(8'h2A, d);
      chk("R10 unmapped reads zero", {24'd0, d}, 32'h00);
   endtask

   // R7: foreign address
   task automatic t_mismatch();
      logic a0, a1, a2;
      logic [7:0] d;
      bus_start();
      wbyte({7'h40, 1'b0}, a0);
      wbyte(8'h00, a1);
      wbyte(8'h99, a2);
      bus_stop();
      chk("R7 no ack anywhere", {29'd0, a0, a1, a2}, 32'h0);
      chk("R7 load line untouched", {24'd0, loadline_pct}, 32'h55);
      bus_start();
      wbyte({7'h31, 1'b1}, a0);
      rbyte(1'b1, d);
      bus_stop();
      chk("R7 foreign read no ack", {31'd0, a0}, 32'h0);
      chk("R7 foreign read bus idle", {24'd0, d}, 32'hFF);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      tick(5);
      t_strap();
      t_strap_hold();
      t_write();
      t_read();
      t_thresholds();
      t_status();
      t_unmapped();
      t_mismatch();
      tick(10);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule